// File: doc/BRIEF.md
# Debug Vector Catch Controller

This block holds a 32-bit control word of vector-catch enables and compares every instruction fetch against the exception vector table. When a fetch hits a vector slot whose enable is set in the active bank, a one-cycle debug event is raised. Enables are kept in separate banks for secure state, non-secure state and monitor mode. Which banks exist depends on an elaboration-time configuration parameter that describes the highest privilege level of the core.

Software reaches the word through a system-register port. Each request carries a read/write strobe, write data, the requester's privilege level (0 to 3) and the trap-control bits of the higher levels. One cycle after the request, the port returns an acknowledge and exactly one outcome: read data, an undefined-instruction flag, or a trap request with a target level and a syndrome code.

The configuration parameter `CFG` takes one of three values: 0 (no level 3), 1 (level 3 runs the 64-bit state) or 2 (level 3 runs the 32-bit state).

Top module: `vcatch_ctrl`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after it rises, `acc_ack_o`, `acc_undef_o`, `acc_trap_o` and `catch_o` are 0 and `acc_rdata_o` is zero.
- R2: A request at privilege level 0 gives `acc_ack_o`=1 and `acc_undef_o`=1 one cycle later, with no trap.
- R3: A request at level 1 traps to level 2 when `l2_enable_i` is set and either `l2_trap_all_i` or `l2_trap_dbg_i` is set. The response is `acc_trap_lvl_o`=2 and `acc_trap_syn_o`=0x05. This check wins over the level-3 trap.
- R4: In configuration 1 only, a request at level 1 or level 2 with `l3_trap_dbg_i` set, and not already trapped by R3, traps to level 3 with syndrome 0x05.
- R5: A request at level 3 always succeeds. A read that succeeds returns the stored word one cycle later.
- R6: A request that is undefined or trapped leaves the stored word unchanged and returns zero read data. A successful write also returns zero read data.
- R7: Only implemented bits store written data. Every other bit reads as zero. The implemented bits are 1-4 and 6-7 in configuration 0; those bits plus 25-28 and 30-31 in configuration 1; and all of those plus 10-12 and 14-15 in configuration 2.
- R8: A fetch with `fetch_valid_i` set at an address equal to `vec_base_i` + 4*k, whose bank bit k is set, raises `catch_o` on the next cycle for exactly one cycle. The slot offsets are: 0x04 undefined instruction, 0x08 call, 0x0C prefetch abort, 0x10 data abort, 0x18 IRQ, 0x1C FIQ.
- R9: In configurations 1 and 2, the secure bank is bits 7:0 and the non-secure bank is bits 31:24, selected by `sec_state_i`. In configuration 2, `mon_mode_i`=1 selects bits 15:8 and takes precedence over the security state.
- R10: In configuration 0, bits 7:0 form the only bank, and `sec_state_i` and `mon_mode_i` have no effect.
- R11: A fetch at offset 0x00, at 0x14, at an offset of 0x20 or more, or at an address not 4-byte aligned to the base never raises `catch_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Register access request |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_wdata_i | input | 32 | Write data |
| acc_priv_i | input | 2 | Privilege level of requester |
| l2_enable_i | input | 1 | Level 2 is enabled |
| l2_trap_all_i | input | 1 | Level 2 general debug trap enable |
| l2_trap_dbg_i | input | 1 | Level 2 debug-register trap enable |
| l3_trap_dbg_i | input | 1 | Level 3 debug-register trap enable |
| acc_ack_o | output | 1 | Response valid, one cycle after request |
| acc_rdata_o | output | 32 | Read data |
| acc_undef_o | output | 1 | Access is undefined |
| acc_trap_o | output | 1 | Access traps |
| acc_trap_lvl_o | output | 2 | Trap target level |
| acc_trap_syn_o | output | 6 | Trap syndrome code |
| fetch_valid_i | input | 1 | Instruction fetch valid |
| fetch_addr_i | input | ADDR_W | Fetch address |
| vec_base_i | input | ADDR_W | Vector table base |
| sec_state_i | input | 1 | 1 = secure state |
| mon_mode_i | input | 1 | 1 = monitor mode |
| catch_o | output | 1 | Vector catch event pulse |

## Verification
The assertions assume that a request is one cycle wide, so every acknowledge follows its own request. They also assume that each privilege and trap-control input holds a defined value whenever `acc_valid_i` is set. The stimulus drives single-cycle requests and single-cycle fetches on the falling edge, and it always releases the strobe before the next request. Because the stored word has no defined value after reset, the stimulus writes it at level 3 before it makes any fetch-match check. It draws the vector base aligned to 32 bytes and the fetch offsets from a window that covers every slot, the reserved slots, offsets beyond the table and misaligned offsets.

// File: rtl/vcatch_pkg.sv
package vcatch_pkg;
  typedef enum logic [1:0] {
    VC_NO_L3     = 2'd0,
    VC_L3_WIDE   = 2'd1,
    VC_L3_NARROW = 2'd2
  } vc_cfg_e;

  localparam int unsigned DW     = 32;
  localparam int unsigned SLOTS  = 8;
  localparam logic [5:0]  TRAP_SYN = 6'h05;

  typedef struct packed {
    logic       undef;
    logic       trap;
    logic [1:0] lvl;
  } acc_res_t;

  // implemented enable bits per configuration
  function automatic logic [DW-1:0] impl_mask(vc_cfg_e c);
    logic [DW-1:0] m;
    m = 32'h0000_00DE;
    if (c != VC_NO_L3)     m |= 32'hDE00_0000;
    if (c == VC_L3_NARROW) m |= 32'h0000_DC00;
    return m;
  endfunction
endpackage

// File: rtl/vcatch_store.sv
module vcatch_store
  import vcatch_pkg::*;
#(
  parameter vc_cfg_e CFG = VC_L3_NARROW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  localparam logic [DW-1:0] MASK = impl_mask(CFG);

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (MASK[i]) begin : g_impl
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      bit_q <= 1'b0;
        else if (wr_en_i) bit_q <= wdata_i[i];
      end
      assign q_o[i] = bit_q;
    end else begin : g_resv
      assign q_o[i] = 1'b0;
    end
  end

  a_r6_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(q_o));
  a_r7_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (q_o == ($past(wdata_i) & MASK)));
endmodule

// File: rtl/vcatch_access.sv
module vcatch_access
  import vcatch_pkg::*;
#(
  parameter vc_cfg_e CFG = VC_L3_NARROW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          write_i,
  input  logic [1:0]    priv_i,
  input  logic          l2_en_i,
  input  logic          l2_all_i,
  input  logic          l2_dbg_i,
  input  logic          l3_dbg_i,
  input  logic [DW-1:0] reg_q_i,
  output logic          wr_en_o,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic          undef_o,
  output logic          trap_o,
  output logic [1:0]    trap_lvl_o,
  output logic [5:0]    trap_syn_o
);
  localparam bit HAS_L3_TRAP = (CFG == VC_L3_WIDE);

  acc_res_t res;
  logic     grant;

  always_comb begin
    res = '0;
    unique case (priv_i)
      2'd0: res.undef = 1'b1;
      2'd1: begin
        if (l2_en_i && (l2_all_i || l2_dbg_i)) begin
          res.trap = 1'b1;
          res.lvl  = 2'd2;
        end else if (HAS_L3_TRAP && l3_dbg_i) begin
          res.trap = 1'b1;
          res.lvl  = 2'd3;
        end
      end
      2'd2: begin
        if (HAS_L3_TRAP && l3_dbg_i) begin
          res.trap = 1'b1;
          res.lvl  = 2'd3;
        end
      end
      default: ;
    endcase
  end

  assign grant   = valid_i && !res.undef && !res.trap;
  assign wr_en_o = grant && write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o      <= 1'b0;
      rdata_o    <= '0;
      undef_o    <= 1'b0;
      trap_o     <= 1'b0;
      trap_lvl_o <= 2'd0;
      trap_syn_o <= 6'd0;
    end else begin
      ack_o      <= valid_i;
      rdata_o    <= (grant && !write_i) ? reg_q_i : '0;
      undef_o    <= valid_i && res.undef;
      trap_o     <= valid_i && res.trap;
      trap_lvl_o <= (valid_i && res.trap) ? res.lvl : 2'd0;
      trap_syn_o <= (valid_i && res.trap) ? TRAP_SYN : 6'd0;
    end
  end

  a_r2_level0_undef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && priv_i == 2'd0) |=> (ack_o && undef_o && !trap_o));
  a_r3_level2_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && priv_i == 2'd1 && l2_en_i && (l2_all_i || l2_dbg_i))
      |=> (trap_o && trap_lvl_o == 2'd2 && trap_syn_o == 6'h05));
  a_r5_level3_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && priv_i == 2'd3) |=> (ack_o && !undef_o && !trap_o));
  a_r6_fault_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (undef_o || trap_o) |-> (rdata_o == '0 && !$onehot({undef_o, trap_o}) == 1'b0));
endmodule

// File: rtl/vcatch_match.sv
module vcatch_match
  import vcatch_pkg::*;
#(
  parameter vc_cfg_e     CFG    = VC_L3_NARROW,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW-1:0]     en_i,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              sec_i,
  input  logic              mon_i,
  output logic              catch_o
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned TOP_LO = SLOT_W + 2;

  logic [ADDR_W-1:0] diff;
  logic              in_table;
  logic [SLOT_W-1:0] slot;
  logic [SLOTS-1:0]  bank;

  assign diff     = addr_i - base_i;
  assign in_table = (diff[ADDR_W-1:TOP_LO] == '0) && (diff[1:0] == 2'b00);
  assign slot     = diff[TOP_LO-1:2];

  if (CFG == VC_NO_L3) begin : g_single
    assign bank = en_i[SLOTS-1:0];
  end else if (CFG == VC_L3_WIDE) begin : g_two
    assign bank = sec_i ? en_i[SLOTS-1:0] : en_i[DW-1:DW-SLOTS];
  end else begin : g_three
    assign bank = mon_i ? en_i[2*SLOTS-1:SLOTS]
                : (sec_i ? en_i[SLOTS-1:0] : en_i[DW-1:DW-SLOTS]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) catch_o <= 1'b0;
    else         catch_o <= valid_i && in_table && bank[slot];
  end

  a_r8_needs_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !catch_o);
  a_r11_slot_zero_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr_i == base_i) |=> !catch_o);
endmodule

// File: rtl/vcatch_ctrl.sv
module vcatch_ctrl
  import vcatch_pkg::*;
#(
  parameter vc_cfg_e     CFG    = VC_L3_NARROW,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [31:0]       acc_wdata_i,
  input  logic [1:0]        acc_priv_i,
  input  logic              l2_enable_i,
  input  logic              l2_trap_all_i,
  input  logic              l2_trap_dbg_i,
  input  logic              l3_trap_dbg_i,
  output logic              acc_ack_o,
  output logic [31:0]       acc_rdata_o,
  output logic              acc_undef_o,
  output logic              acc_trap_o,
  output logic [1:0]        acc_trap_lvl_o,
  output logic [5:0]        acc_trap_syn_o,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [ADDR_W-1:0] vec_base_i,
  input  logic              sec_state_i,
  input  logic              mon_mode_i,
  output logic              catch_o
);
  logic [DW-1:0] reg_q;
  logic          wr_en;

  vcatch_access #(.CFG(CFG)) u_access (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (acc_valid_i),
    .write_i    (acc_write_i),
    .priv_i     (acc_priv_i),
    .l2_en_i    (l2_enable_i),
    .l2_all_i   (l2_trap_all_i),
    .l2_dbg_i   (l2_trap_dbg_i),
    .l3_dbg_i   (l3_trap_dbg_i),
    .reg_q_i    (reg_q),
    .wr_en_o    (wr_en),
    .ack_o      (acc_ack_o),
    .rdata_o    (acc_rdata_o),
    .undef_o    (acc_undef_o),
    .trap_o     (acc_trap_o),
    .trap_lvl_o (acc_trap_lvl_o),
    .trap_syn_o (acc_trap_syn_o)
  );

  vcatch_store #(.CFG(CFG)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .wdata_i (acc_wdata_i),
    .q_o     (reg_q)
  );

  vcatch_match #(.CFG(CFG), .ADDR_W(ADDR_W)) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (reg_q),
    .valid_i (fetch_valid_i),
    .addr_i  (fetch_addr_i),
    .base_i  (vec_base_i),
    .sec_i   (sec_state_i),
    .mon_i   (mon_mode_i),
    .catch_o (catch_o)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!acc_ack_o && !catch_o));
  a_r4_trap_level_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_trap_o |-> (acc_trap_lvl_o == 2'd2 || (CFG == VC_L3_WIDE && acc_trap_lvl_o == 2'd3)));
  a_r6_single_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_undef_o, acc_trap_o}));
endmodule

// File: tb/vcatch_ctrl_test.sv
module vcatch_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [31:0] wdata = '0;
  logic [1:0]  priv = '0;
  logic        l2e = 0, l2a = 0, l2d = 0, l3d = 0;
  logic        fv = 0, fsec = 0, fmon = 0;
  logic [31:0] faddr = '0, fbase = '0;

  logic        ack [3];
  logic [31:0] rd [3];
  logic        und [3];
  logic        trp [3];
  logic [1:0]  lvl [3];
  logic [5:0]  syn [3];
  logic        cat [3];

  logic [31:0] sh [3];
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vcatch_ctrl #(.CFG(vcatch_pkg::VC_L3_NARROW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
    .acc_wdata_i(wdata), .acc_priv_i(priv), .l2_enable_i(l2e), .l2_trap_all_i(l2a),
    .l2_trap_dbg_i(l2d), .l3_trap_dbg_i(l3d), .acc_ack_o(ack[0]), .acc_rdata_o(rd[0]),
    .acc_undef_o(und[0]), .acc_trap_o(trp[0]), .acc_trap_lvl_o(lvl[0]),
    .acc_trap_syn_o(syn[0]), .fetch_valid_i(fv), .fetch_addr_i(faddr),
    .vec_base_i(fbase), .sec_state_i(fsec), .mon_mode_i(fmon), .catch_o(cat[0]));

  vcatch_ctrl #(.CFG(vcatch_pkg::VC_L3_WIDE)) uut_wide (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
    .acc_wdata_i(wdata), .acc_priv_i(priv), .l2_enable_i(l2e), .l2_trap_all_i(l2a),
    .l2_trap_dbg_i(l2d), .l3_trap_dbg_i(l3d), .acc_ack_o(ack[1]), .acc_rdata_o(rd[1]),
    .acc_undef_o(und[1]), .acc_trap_o(trp[1]), .acc_trap_lvl_o(lvl[1]),
    .acc_trap_syn_o(syn[1]), .fetch_valid_i(fv), .fetch_addr_i(faddr),
    .vec_base_i(fbase), .sec_state_i(fsec), .mon_mode_i(fmon), .catch_o(cat[1]));

  vcatch_ctrl #(.CFG(vcatch_pkg::VC_NO_L3)) uut_flat (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
    .acc_wdata_i(wdata), .acc_priv_i(priv), .l2_enable_i(l2e), .l2_trap_all_i(l2a),
    .l2_trap_dbg_i(l2d), .l3_trap_dbg_i(l3d), .acc_ack_o(ack[2]), .acc_rdata_o(rd[2]),
    .acc_undef_o(und[2]), .acc_trap_o(trp[2]), .acc_trap_lvl_o(lvl[2]),
    .acc_trap_syn_o(syn[2]), .fetch_valid_i(fv), .fetch_addr_i(faddr),
    .vec_base_i(fbase), .sec_state_i(fsec), .mon_mode_i(fmon), .catch_o(cat[2]));

  function automatic int cfg_of(int ci);
    return (ci == 0) ? 2 : (ci == 1) ? 1 : 0;
  endfunction

  function automatic logic [31:0] mask_of(int cfg);
    if (cfg == 0) return 32'h0000_00DE;
    if (cfg == 1) return 32'hDE00_00DE;
    return 32'hDE00_DCDE;
  endfunction

  // {undef, trap, lvl[1:0]}
  function automatic logic [3:0] exp_res(int cfg, logic [1:0] p, logic e2, logic a2,
                                         logic d2, logic d3);
    if (p == 2'd0) return 4'b1000;
    if (p == 2'd1 && e2 && (a2 || d2)) return 4'b0110;
    if ((p == 2'd1 || p == 2'd2) && cfg == 1 && d3) return 4'b0111;
    return 4'b0000;
  endfunction

  function automatic logic exp_catch(int cfg, logic [31:0] r, logic [31:0] a,
                                     logic [31:0] b, logic s, logic m);
    logic [31:0] d;
    int k;
    d = a - b;
    if (d > 32'd31 || d[1:0] != 2'b00) return 1'b0;
    k = int'(d[4:2]);
    if (cfg == 0) return r[k];
    if (cfg == 2 && m) return r[8 + k];
    return s ? r[k] : r[24 + k];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(logic [1:0] p, logic w, logic [31:0] d,
                        logic e2, logic a2, logic d2, logic d3);
    @(negedge clk);
    acc_valid = 1; acc_write = w; wdata = d; priv = p;
    l2e = e2; l2a = a2; l2d = d2; l3d = d3;
    @(negedge clk);
    acc_valid = 0;
    for (int ci = 0; ci < 3; ci++) begin
      logic [3:0] e;
      logic ok;
      string tag;
      e  = exp_res(cfg_of(ci), p, e2, a2, d2, d3);
      ok = !e[3] && !e[2];
      tag = (p == 2'd0) ? "R2" : (e[2] && e[1:0] == 2'd2) ? "R3" :
            (e[2] && e[1:0] == 2'd3) ? "R4" : "R5";
      check(tag, {28'd0, ack[ci], und[ci], trp[ci], 1'b0}, {28'd0, 1'b1, e[3], e[2], 1'b0});
      check(tag, {30'd0, lvl[ci]}, {30'd0, e[2] ? e[1:0] : 2'd0});
      check(tag, {26'd0, syn[ci]}, e[2] ? 32'h5 : 32'h0);
      check(ok ? "R7" : "R6", rd[ci], (ok && !w) ? sh[ci] : 32'h0);
      if (ok && w) sh[ci] = d & mask_of(cfg_of(ci));
    end
  endtask

  task automatic fetch(logic [31:0] b, logic [31:0] a, logic s, logic m);
    @(negedge clk);
    fv = 1; fbase = b; faddr = a; fsec = s; fmon = m;
    @(negedge clk);
    fv = 0;
    for (int ci = 0; ci < 3; ci++) begin
      logic [31:0] dd;
      string tag;
      dd = a - b;
      tag = (dd > 32'd31 || dd[1:0] != 0 || dd == 0 || dd == 32'h14) ? "R11" :
            (cfg_of(ci) == 0) ? "R10" : "R9";
      check(tag, {31'd0, cat[ci]}, {31'd0, exp_catch(cfg_of(ci), sh[ci], a, b, s, m)});
    end
    @(negedge clk);
    for (int ci = 0; ci < 3; ci++) check("R8", {31'd0, cat[ci]}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_1234);
    for (int ci = 0; ci < 3; ci++) sh[ci] = '0;
    repeat (3) @(negedge clk);
    for (int ci = 0; ci < 3; ci++) begin
      check("R1", {30'd0, ack[ci], cat[ci]}, 32'h0);
      check("R1", rd[ci], 32'h0);
    end
    rst_n = 1;
    @(negedge clk);
    for (int ci = 0; ci < 3; ci++) check("R1", {29'd0, ack[ci], und[ci], cat[ci]}, 32'h0);

    // field masks, full write then readback
    access(2'd3, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    access(2'd3, 0, 32'h0, 0, 0, 0, 0);
    // level 0 write is undefined and leaves contents
    access(2'd0, 1, 32'h0, 0, 0, 0, 0);
    access(2'd3, 0, 32'h0, 0, 0, 0, 0);
    // level 2 trap wins over level 3 trap
    access(2'd1, 1, 32'h0, 1, 0, 1, 1);
    access(2'd1, 1, 32'h0, 1, 1, 0, 1);
    // level 3 trap at levels 1 and 2
    access(2'd2, 1, 32'h0, 1, 1, 1, 1);
    access(2'd1, 0, 32'h0, 0, 1, 1, 1);
    access(2'd3, 0, 32'h0, 1, 1, 1, 1);

    // distinct banks: secure FIQ, monitor call, non-secure undefined
    access(2'd3, 1, 32'h0200_0480, 0, 0, 0, 0);
    fetch(32'h0000_1000, 32'h0000_101C, 1, 0);
    fetch(32'h0000_1000, 32'h0000_101C, 0, 0);
    fetch(32'h0000_1000, 32'h0000_1008, 1, 1);
    fetch(32'h0000_1000, 32'h0000_1004, 0, 0);
    fetch(32'h0000_1000, 32'h0000_1004, 0, 1);
    // reserved and out-of-table offsets with everything enabled
    access(2'd3, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    fetch(32'h0000_2000, 32'h0000_2000, 1, 0);
    fetch(32'h0000_2000, 32'h0000_2014, 0, 1);
    fetch(32'h0000_2000, 32'h0000_2020, 1, 0);
    fetch(32'h0000_2000, 32'h0000_2006, 0, 0);
    fetch(32'h0000_2000, 32'h0000_1FFC, 0, 0);

    for (int i = 0; i < 60; i++) begin
      logic [31:0] r;
      r = $urandom;
      access(r[1:0], r[2], $urandom, r[3], r[4], r[5], r[6]);
    end
    for (int i = 0; i < 300; i++) begin
      logic [31:0] b, r;
      if (i % 25 == 0) access(2'd3, 1, $urandom, 0, 0, 0, 0);
      b = $urandom & 32'hFFFF_FFE0;
      r = $urandom;
      fetch(b, b + (r[7] ? {26'd0, r[5:0]} : {27'd0, r[4:2], 2'b00}), r[8], r[9]);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule